// File: doc/BRIEF.md
# Performance Monitor User-Access Control Register with Trap Arbitration

This block holds the control word that decides how much of a performance monitor unprivileged software may touch, and it judges every coprocessor-style read or write aimed at that word. Each access carries the privilege level it comes from (0 to 3), its direction, the five coprocessor select fields and the write data. It also carries a set of configuration and trap flags. These say whether the hypervisor level (EL2) is enabled and whether it runs in 32- or 64-bit state, whether the monitor level (EL3) exists and its state, and the state of EL1. They also give the host-mode flag for EL0, the fine-grained read trap with its feature and monitor enables, the hypervisor and monitor trap bits, and the secure-debug undefined controls.

The verdict comes out in the same cycle as the access, as a one-hot result: completed, undefined, trapped to EL2 or trapped to EL3. A syndrome class code and the read data come out with it. The control word is written at the next rising clock edge, and only when a write completes. Exception entry and the counters themselves sit elsewhere.

Top module: `perfmon_user_gate`

## Requirements
- R1: An access is considered only when its select fields equal coprocessor 15, opc1 0, CRn 9, CRm 14, opc2 0. For any other selection the result is 4'b0000, the read data is zero and the stored word is unchanged.
- R2: After the active-low synchronous reset, every stored bit is 0.
- R3: A write from EL0 gives UNDEFINED whatever the trap flags are, and it leaves the stored word unchanged.
- R4: An access from EL3 always completes, whatever the trap flags are.
- R5: Only bits 6, 3, 2, 1 and 0 are stored. All other bits read as zero and ignore writes.
- R6: For EL1 accesses and EL0 reads, the checks run in this order, and the first hit wins. (1) Monitor PMU trap with undefined-priority gives UNDEFINED. (2) Hypervisor coprocessor-9 trap gives a trap to EL2. (3) At EL0 only, the fine-grained read trap gives a trap to EL2. (4) Hypervisor PMU trap gives a trap to EL2. (5) Monitor PMU trap gives the R10 outcome. (6) Otherwise the access completes.
- R7: Hypervisor checks use the 64-bit trap bits when EL2 is in 64-bit state and the 32-bit trap bits when it is in 32-bit state. At EL0 in host mode the 64-bit coprocessor-9 check is skipped.
- R8: The fine-grained read trap applies only to an EL0 read, and only when all of these hold: EL2 is enabled, the feature is present, EL1 is in 64-bit state, EL0 is not in host mode, and either EL3 is absent or its fine-grained enable is set.
- R9: An access from EL2 sees only the two monitor checks, undefined-priority first. Hypervisor and fine-grained bits have no effect on it.
- R10: When the monitor PMU trap decides the outcome, the result is UNDEFINED if the secure-debug undefined flag is set, and a trap to EL3 otherwise.
- R11: Monitor checks apply only when EL3 is present and in 64-bit state. Hypervisor checks apply only when EL2 is enabled.
- R12: The class code is 6'h03 on a trap to EL2 or EL3, and 0 otherwise.
- R13: The stored word changes only on a write whose result is complete. Read data equals the stored word on a completed read and is zero otherwise.
- R14: The result encodes complete=4'b0001, undefined=4'b0010, trap to EL2=4'b0100, trap to EL3=4'b1000. Exactly one bit is set for a valid, selected access, and none otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_el | input | 2 | Privilege level of the access |
| sel_coproc | input | 4 | Coprocessor number |
| sel_opc1 | input | 3 | First opcode field |
| sel_crn | input | 4 | Primary register field |
| sel_crm | input | 4 | Secondary register field |
| sel_opc2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| cfg_el2_on | input | 1 | Hypervisor level enabled |
| cfg_el2_is32 | input | 1 | Hypervisor level in 32-bit state |
| cfg_el3_on | input | 1 | Monitor level present |
| cfg_el3_is32 | input | 1 | Monitor level in 32-bit state |
| cfg_el1_is32 | input | 1 | EL1 in 32-bit state |
| cfg_el0_host | input | 1 | EL0 running under host hypervisor |
| cfg_fgt_impl | input | 1 | Fine-grained trap feature present |
| cfg_mon_fgt_en | input | 1 | Monitor enable for fine-grained traps |
| hyp64_cp9_trap | input | 1 | 64-bit hypervisor coprocessor-9 trap |
| hyp32_cp9_trap | input | 1 | 32-bit hypervisor coprocessor-9 trap |
| hyp64_pmu_trap | input | 1 | 64-bit hypervisor PMU trap |
| hyp32_pmu_trap | input | 1 | 32-bit hypervisor PMU trap |
| fgt_rd_trap | input | 1 | Fine-grained read trap for this word |
| mon_pmu_trap | input | 1 | Monitor PMU trap |
| mon_sdd_prio | input | 1 | Secure-debug undefined takes priority |
| mon_sdd_undef | input | 1 | Secure-debug undefined condition |
| acc_result | output | 4 | One-hot outcome |
| trap_class | output | 6 | Syndrome class for traps |
| acc_rdata | output | 32 | Read data |

## Verification
The trap chain is driven with every flag set at once, and then the flags are cleared one by one from the top. Each step moves the verdict to the next rung, so this sequence tells a wrong ordering apart from a wrong single condition. Each qualifier of the fine-grained and hypervisor paths is then toggled alone while its trap bit stays set. This separates 32-bit from 64-bit bit selection, host-mode skipping and EL2/EL3 gating. Reads from EL3 after all-ones, reserved-only, rejected and mis-selected writes show which bits are stored and that only completed writes change them.

// File: rtl/perfmon_gate_pkg.sv
package perfmon_gate_pkg;
  localparam int REG_W   = 32;
  localparam int CLASS_W = 6;
  localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h03;

  // stored bit positions (software-visible layout)
  localparam int POS_IDTRAP = 6;
  localparam int POS_CNTRD  = 3;
  localparam int POS_CYCRD  = 2;
  localparam int POS_SWINC  = 1;
  localparam int POS_ALLEN  = 0;

  typedef enum logic [3:0] {
    OUT_NONE  = 4'b0000,
    OUT_DONE  = 4'b0001,
    OUT_UNDEF = 4'b0010,
    OUT_TRAP2 = 4'b0100,
    OUT_TRAP3 = 4'b1000
  } outcome_e;

  typedef struct packed {
    logic el2_on;
    logic el2_is32;
    logic el3_on;
    logic el3_is32;
    logic el1_is32;
    logic el0_host;
    logic fgt_impl;
    logic mon_fgt_en;
    logic hyp64_cp9;
    logic hyp32_cp9;
    logic hyp64_pmu;
    logic hyp32_pmu;
    logic fgt_rd;
    logic mon_pmu;
    logic sdd_prio;
    logic sdd_undef;
  } trap_cfg_t;

  function automatic logic [REG_W-1:0] keep_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[POS_IDTRAP] = 1'b1;
    m[POS_CNTRD]  = 1'b1;
    m[POS_CYCRD]  = 1'b1;
    m[POS_SWINC]  = 1'b1;
    m[POS_ALLEN]  = 1'b1;
    return m;
  endfunction

  function automatic logic is_trap(input outcome_e o);
    return (o == OUT_TRAP2) || (o == OUT_TRAP3);
  endfunction
endpackage

// File: rtl/pgate_select_dec.sv
module pgate_select_dec #(
  parameter logic [3:0] SEL_COPROC = 4'd15,
  parameter logic [2:0] SEL_OPC1   = 3'd0,
  parameter logic [3:0] SEL_CRN    = 4'd9,
  parameter logic [3:0] SEL_CRM    = 4'd14,
  parameter logic [2:0] SEL_OPC2   = 3'd0
) (
  input  logic [3:0] coproc,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  output logic       hit
);
  assign hit = (coproc == SEL_COPROC) && (opc1 == SEL_OPC1) &&
               (crn == SEL_CRN) && (crm == SEL_CRM) && (opc2 == SEL_OPC2);
endmodule

// File: rtl/pgate_trap_arbiter.sv
module pgate_trap_arbiter
  import perfmon_gate_pkg::*;
(
  input  logic               req,
  input  logic               write,
  input  logic [1:0]         el,
  input  trap_cfg_t          cfg,
  output outcome_e           outcome,
  output logic [CLASS_W-1:0] class_code,
  output logic               mon_prio_hit,
  output logic               hv_cp9_hit,
  output logic               fgt_hit,
  output logic               hv_pmu_hit,
  output logic               mon_pmu_hit
);
  logic mon_live;
  logic at_el0;
  outcome_e mon_verdict;

  assign at_el0   = (el == 2'd0);
  assign mon_live = cfg.el3_on & ~cfg.el3_is32;

  assign mon_prio_hit = mon_live & cfg.sdd_prio & cfg.mon_pmu;
  assign mon_pmu_hit  = mon_live & cfg.mon_pmu;
  assign hv_cp9_hit   = cfg.el2_on &
                        (cfg.el2_is32 ? cfg.hyp32_cp9
                                      : (cfg.hyp64_cp9 & ~(at_el0 & cfg.el0_host)));
  assign hv_pmu_hit   = cfg.el2_on & (cfg.el2_is32 ? cfg.hyp32_pmu : cfg.hyp64_pmu);
  assign fgt_hit      = at_el0 & cfg.el2_on & ~cfg.el1_is32 & ~cfg.el0_host &
                        cfg.fgt_impl & (~cfg.el3_on | cfg.mon_fgt_en) & cfg.fgt_rd;

  assign mon_verdict  = cfg.sdd_undef ? OUT_UNDEF : OUT_TRAP3;

  always_comb begin
    outcome = OUT_NONE;
    if (req) begin
      unique case (el)
        2'd3: outcome = OUT_DONE;
        2'd2: begin
          if (mon_prio_hit)      outcome = OUT_UNDEF;
          else if (mon_pmu_hit)  outcome = mon_verdict;
          else                   outcome = OUT_DONE;
        end
        default: begin
          if (at_el0 && write)   outcome = OUT_UNDEF;
          else if (mon_prio_hit) outcome = OUT_UNDEF;
          else if (hv_cp9_hit)   outcome = OUT_TRAP2;
          else if (fgt_hit)      outcome = OUT_TRAP2;
          else if (hv_pmu_hit)   outcome = OUT_TRAP2;
          else if (mon_pmu_hit)  outcome = mon_verdict;
          else                   outcome = OUT_DONE;
        end
      endcase
    end
  end

  assign class_code = is_trap(outcome) ? TRAP_CLASS : '0;
endmodule

// File: rtl/pgate_ctrl_store.sv
module pgate_ctrl_store
  import perfmon_gate_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] KEEP = W'(keep_mask());

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_flop
      logic b;
      always_ff @(posedge clk) begin
        if (!rst_n)      b <= 1'b0;
        else if (commit) b <= wdata[i];
      end
      assign q[i] = b;
    end else begin : g_zero
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/perfmon_user_gate.sv
module perfmon_user_gate
  import perfmon_gate_pkg::*;
#(
  parameter logic [3:0] SEL_COPROC = 4'd15,
  parameter logic [2:0] SEL_OPC1   = 3'd0,
  parameter logic [3:0] SEL_CRN    = 4'd9,
  parameter logic [3:0] SEL_CRM    = 4'd14,
  parameter logic [2:0] SEL_OPC2   = 3'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_el,
  input  logic [3:0]  sel_coproc,
  input  logic [2:0]  sel_opc1,
  input  logic [3:0]  sel_crn,
  input  logic [3:0]  sel_crm,
  input  logic [2:0]  sel_opc2,
  input  logic [31:0] acc_wdata,
  input  logic        cfg_el2_on,
  input  logic        cfg_el2_is32,
  input  logic        cfg_el3_on,
  input  logic        cfg_el3_is32,
  input  logic        cfg_el1_is32,
  input  logic        cfg_el0_host,
  input  logic        cfg_fgt_impl,
  input  logic        cfg_mon_fgt_en,
  input  logic        hyp64_cp9_trap,
  input  logic        hyp32_cp9_trap,
  input  logic        hyp64_pmu_trap,
  input  logic        hyp32_pmu_trap,
  input  logic        fgt_rd_trap,
  input  logic        mon_pmu_trap,
  input  logic        mon_sdd_prio,
  input  logic        mon_sdd_undef,
  output logic [3:0]  acc_result,
  output logic [5:0]  trap_class,
  output logic [31:0] acc_rdata
);
  trap_cfg_t cfg;
  outcome_e  outcome;
  logic      sel_hit;
  logic      req;
  logic      commit;
  logic      rd_done;
  logic [REG_W-1:0] ctrl_q;
  logic mon_prio_hit, hv_cp9_hit, fgt_hit, hv_pmu_hit, mon_pmu_hit;

  assign cfg = '{el2_on: cfg_el2_on, el2_is32: cfg_el2_is32,
                 el3_on: cfg_el3_on, el3_is32: cfg_el3_is32,
                 el1_is32: cfg_el1_is32, el0_host: cfg_el0_host,
                 fgt_impl: cfg_fgt_impl, mon_fgt_en: cfg_mon_fgt_en,
                 hyp64_cp9: hyp64_cp9_trap, hyp32_cp9: hyp32_cp9_trap,
                 hyp64_pmu: hyp64_pmu_trap, hyp32_pmu: hyp32_pmu_trap,
                 fgt_rd: fgt_rd_trap, mon_pmu: mon_pmu_trap,
                 sdd_prio: mon_sdd_prio, sdd_undef: mon_sdd_undef};

  pgate_select_dec #(
    .SEL_COPROC(SEL_COPROC), .SEL_OPC1(SEL_OPC1), .SEL_CRN(SEL_CRN),
    .SEL_CRM(SEL_CRM), .SEL_OPC2(SEL_OPC2)
  ) i_dec (
    .coproc(sel_coproc), .opc1(sel_opc1), .crn(sel_crn),
    .crm(sel_crm), .opc2(sel_opc2), .hit(sel_hit)
  );

  assign req = acc_valid & sel_hit;

  pgate_trap_arbiter i_arb (
    .req(req), .write(acc_write), .el(acc_el), .cfg(cfg),
    .outcome(outcome), .class_code(trap_class),
    .mon_prio_hit(mon_prio_hit), .hv_cp9_hit(hv_cp9_hit), .fgt_hit(fgt_hit),
    .hv_pmu_hit(hv_pmu_hit), .mon_pmu_hit(mon_pmu_hit)
  );

  assign commit  = (outcome == OUT_DONE) &  acc_write;
  assign rd_done = (outcome == OUT_DONE) & ~acc_write;

  pgate_ctrl_store #(.W(REG_W)) i_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .wdata(acc_wdata), .q(ctrl_q)
  );

  assign acc_result = outcome;
  assign acc_rdata  = rd_done ? ctrl_q : '0;
endmodule

// File: rtl/pgate_checker.sv
module pgate_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [1:0]  acc_el,
  input logic        sel_hit,
  input logic [3:0]  acc_result,
  input logic [5:0]  trap_class,
  input logic [31:0] acc_rdata,
  input logic [31:0] ctrl_q,
  input logic        mon_prio_hit,
  input logic        mon_pmu_hit,
  input logic        mon_sdd_undef
);
  logic req;
  assign req = acc_valid & sel_hit;

  a_r14_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $countones(acc_result) == 1);
  a_r1_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (acc_result == 4'b0000 && acc_rdata == 32'h0));
  a_r12_class: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_result[2] || acc_result[3]) |-> trap_class == 6'h03);
  a_r3_el0_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req && acc_write && acc_el == 2'd0) |-> acc_result == 4'b0010);
  a_r4_el3_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req && acc_el == 2'd3) |-> acc_result == 4'b0001);
  a_r9_el2_no_hyp: assert property (@(posedge clk) disable iff (!rst_n)
    (req && acc_el == 2'd2) |-> !acc_result[2]);
  a_r6_prio_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req && acc_el != 2'd3 && mon_prio_hit) |-> acc_result == 4'b0010);
  a_r10_mon_sdd: assert property (@(posedge clk) disable iff (!rst_n)
    (req && acc_el != 2'd3 && mon_pmu_hit && !mon_sdd_undef) |-> !acc_result[0]);
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && acc_write && acc_result == 4'b0001) |=> $stable(ctrl_q));
  a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & 32'hFFFF_FFB0) == 32'h0);
endmodule

bind perfmon_user_gate pgate_checker i_pgate_checker (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_el(acc_el), .sel_hit(sel_hit), .acc_result(acc_result),
  .trap_class(trap_class), .acc_rdata(acc_rdata), .ctrl_q(ctrl_q),
  .mon_prio_hit(mon_prio_hit), .mon_pmu_hit(mon_pmu_hit),
  .mon_sdd_undef(mon_sdd_undef)
);

// File: tb/test_perfmon_user_gate.sv
module test_perfmon_user_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0] acc_el = 2'd0;
  logic [3:0] sel_coproc = 4'd15, sel_crn = 4'd9, sel_crm = 4'd14;
  logic [2:0] sel_opc1 = 3'd0, sel_opc2 = 3'd0;
  logic [31:0] acc_wdata = '0;
  logic cfg_el2_on, cfg_el2_is32, cfg_el3_on, cfg_el3_is32, cfg_el1_is32, cfg_el0_host;
  logic cfg_fgt_impl, cfg_mon_fgt_en, hyp64_cp9_trap, hyp32_cp9_trap;
  logic hyp64_pmu_trap, hyp32_pmu_trap, fgt_rd_trap, mon_pmu_trap, mon_sdd_prio, mon_sdd_undef;
  logic [3:0] acc_result;
  logic [5:0] trap_class;
  logic [31:0] acc_rdata;

  localparam logic [3:0] R_NONE = 4'b0000, R_DONE = 4'b0001, R_UNDEF = 4'b0010,
                         R_TRAP2 = 4'b0100, R_TRAP3 = 4'b1000;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [3:0] got_res;
  logic [5:0] got_cls;
  logic [31:0] got_rd;

  always #5 clk = ~clk;

  perfmon_user_gate i_perfmon_user_gate (.*);

  task automatic cfg_none();
    {cfg_el2_on, cfg_el2_is32, cfg_el3_on, cfg_el3_is32, cfg_el1_is32, cfg_el0_host,
     cfg_fgt_impl, cfg_mon_fgt_en, hyp64_cp9_trap, hyp32_cp9_trap, hyp64_pmu_trap,
     hyp32_pmu_trap, fgt_rd_trap, mon_pmu_trap, mon_sdd_prio, mon_sdd_undef} = '0;
  endtask

  task automatic cfg_all();
    {cfg_el2_on, cfg_el2_is32, cfg_el3_on, cfg_el3_is32, cfg_el1_is32, cfg_el0_host,
     cfg_fgt_impl, cfg_mon_fgt_en, hyp64_cp9_trap, hyp32_cp9_trap, hyp64_pmu_trap,
     hyp32_pmu_trap, fgt_rd_trap, mon_pmu_trap, mon_sdd_prio, mon_sdd_undef} = '1;
  endtask

  task automatic do_acc(input logic [1:0] el, input logic wr, input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1'b1; acc_el = el; acc_write = wr; acc_wdata = wd;
    #1;
    got_res = acc_result; got_cls = trap_class; got_rd = acc_rdata;
    @(posedge clk);
    #1;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic chk_res(input string tag, input logic [3:0] er, input logic [5:0] ec);
    n_chk++;
    if (got_res !== er || got_cls !== ec) begin
      n_bad++;
      $display("FAIL %s: result/class got %b/%h expected %b/%h", tag, got_res, got_cls, er, ec);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [31:0] ed);
    n_chk++;
    if (got_rd !== ed) begin
      n_bad++;
      $display("FAIL %s: rdata got %h expected %h", tag, got_rd, ed);
    end
  endtask

  task automatic peek(input string tag, input logic [31:0] ed);
    do_acc(2'd3, 1'b0, '0);
    chk_res(tag, R_DONE, 6'h0);
    chk_rd(tag, ed);
  endtask

  task automatic t_reset();
    cfg_none();
    peek("R2/R14 reset value", 32'h0);
  endtask

  task automatic t_layout();
    do_acc(2'd3, 1'b1, 32'hFFFF_FFFF);
    peek("R5 all-ones write keeps 6,3..0", 32'h0000_004F);
    do_acc(2'd3, 1'b1, 32'h0000_0030);
    peek("R5 reserved-only write", 32'h0);
  endtask

  task automatic t_decode();
    sel_crm = 4'd13;
    do_acc(2'd3, 1'b1, 32'h4F);
    chk_res("R1/R14 crm mismatch write", R_NONE, 6'h0);
    sel_crm = 4'd14; sel_opc2 = 3'd1;
    do_acc(2'd3, 1'b0, '0);
    chk_res("R1 opc2 mismatch read", R_NONE, 6'h0);
    chk_rd("R1 opc2 mismatch rdata", 32'h0);
    sel_opc2 = 3'd0;
    peek("R1 word unchanged", 32'h0);
  endtask

  task automatic t_el0_write();
    cfg_none();
    do_acc(2'd0, 1'b1, 32'h1);
    chk_res("R3 EL0 write clean cfg", R_UNDEF, 6'h0);
    cfg_all();
    do_acc(2'd0, 1'b1, 32'h1);
    chk_res("R3 EL0 write all traps", R_UNDEF, 6'h0);
    peek("R3 word unchanged", 32'h0);
  endtask

  task automatic t_el3_always();
    cfg_all();
    do_acc(2'd3, 1'b1, 32'h0F);
    chk_res("R4 EL3 write all traps", R_DONE, 6'h0);
    peek("R4 EL3 read back", 32'h0F);
    cfg_none();
  endtask

  task automatic t_el1_chain();
    cfg_none();
    cfg_el2_on = 1; cfg_el3_on = 1; mon_pmu_trap = 1; mon_sdd_prio = 1;
    hyp64_cp9_trap = 1; hyp64_pmu_trap = 1;
    do_acc(2'd1, 1'b0, '0); chk_res("R6 prio undef first", R_UNDEF, 6'h0);
    mon_sdd_prio = 0;
    do_acc(2'd1, 1'b0, '0); chk_res("R6/R12 cp9 trap", R_TRAP2, 6'h03);
    hyp64_cp9_trap = 0;
    do_acc(2'd1, 1'b0, '0); chk_res("R6 hyp pmu trap", R_TRAP2, 6'h03);
    hyp64_pmu_trap = 0;
    do_acc(2'd1, 1'b0, '0); chk_res("R10/R12 mon trap EL3", R_TRAP3, 6'h03);
    mon_sdd_undef = 1;
    do_acc(2'd1, 1'b0, '0); chk_res("R10 mon sdd undef", R_UNDEF, 6'h0);
    mon_pmu_trap = 0;
    do_acc(2'd1, 1'b0, '0); chk_res("R6 clear completes", R_DONE, 6'h0);
    chk_rd("R13 EL1 read data", 32'h0F);
  endtask

  task automatic t_el0_fgt();
    cfg_none();
    cfg_el2_on = 1; cfg_fgt_impl = 1; fgt_rd_trap = 1; cfg_el3_on = 1;
    do_acc(2'd0, 1'b0, '0); chk_res("R8 mon fgt enable off", R_DONE, 6'h0);
    cfg_mon_fgt_en = 1;
    do_acc(2'd0, 1'b0, '0); chk_res("R8 fgt trap", R_TRAP2, 6'h03);
    cfg_el1_is32 = 1;
    do_acc(2'd0, 1'b0, '0); chk_res("R8 EL1 32-bit", R_DONE, 6'h0);
    cfg_el1_is32 = 0; cfg_el0_host = 1;
    do_acc(2'd0, 1'b0, '0); chk_res("R8 host mode", R_DONE, 6'h0);
    cfg_el0_host = 0;
    do_acc(2'd1, 1'b0, '0); chk_res("R8 EL1 not affected", R_DONE, 6'h0);
    cfg_el3_on = 0; cfg_mon_fgt_en = 0;
    do_acc(2'd0, 1'b0, '0); chk_res("R8 no EL3", R_TRAP2, 6'h03);
    cfg_fgt_impl = 0;
    do_acc(2'd0, 1'b0, '0); chk_res("R8 feature absent", R_DONE, 6'h0);
  endtask

  task automatic t_paths();
    cfg_none();
    cfg_el2_on = 1; hyp32_cp9_trap = 1; hyp32_pmu_trap = 1;
    do_acc(2'd1, 1'b0, '0); chk_res("R7 32-bit bits ignored in 64", R_DONE, 6'h0);
    cfg_el2_is32 = 1;
    do_acc(2'd1, 1'b0, '0); chk_res("R7 32-bit path trap", R_TRAP2, 6'h03);
    hyp32_cp9_trap = 0; hyp32_pmu_trap = 0; hyp64_cp9_trap = 1;
    do_acc(2'd1, 1'b0, '0); chk_res("R7 64-bit bit ignored in 32", R_DONE, 6'h0);
    cfg_el2_is32 = 0; cfg_el0_host = 1;
    do_acc(2'd0, 1'b0, '0); chk_res("R7 host skips cp9", R_DONE, 6'h0);
    hyp64_pmu_trap = 1;
    do_acc(2'd0, 1'b0, '0); chk_res("R7 host pmu trap", R_TRAP2, 6'h03);
  endtask

  task automatic t_el2();
    cfg_none();
    cfg_el2_on = 1; hyp64_cp9_trap = 1; hyp64_pmu_trap = 1;
    cfg_fgt_impl = 1; fgt_rd_trap = 1;
    do_acc(2'd2, 1'b0, '0); chk_res("R9 EL2 ignores hyp bits", R_DONE, 6'h0);
    do_acc(2'd2, 1'b1, 32'h40); chk_res("R9 EL2 write", R_DONE, 6'h0);
    cfg_el3_on = 1; mon_pmu_trap = 1;
    do_acc(2'd2, 1'b0, '0); chk_res("R9/R10 EL2 mon trap", R_TRAP3, 6'h03);
    mon_sdd_prio = 1;
    do_acc(2'd2, 1'b0, '0); chk_res("R9 EL2 prio undef", R_UNDEF, 6'h0);
    peek("R9 EL2 write stored", 32'h40);
  endtask

  task automatic t_gating();
    cfg_none();
    cfg_el3_on = 1; cfg_el3_is32 = 1; mon_pmu_trap = 1; mon_sdd_prio = 1;
    do_acc(2'd1, 1'b0, '0); chk_res("R11 EL3 32-bit no mon check", R_DONE, 6'h0);
    hyp64_cp9_trap = 1; hyp64_pmu_trap = 1;
    do_acc(2'd1, 1'b0, '0); chk_res("R11 EL2 off no hyp check", R_DONE, 6'h0);
  endtask

  task automatic t_commit();
    cfg_none();
    cfg_el2_on = 1; hyp64_pmu_trap = 1;
    do_acc(2'd1, 1'b1, 32'h0E); chk_res("R13 trapped write", R_TRAP2, 6'h03);
    do_acc(2'd1, 1'b0, '0); chk_res("R13 trapped read", R_TRAP2, 6'h03);
    chk_rd("R13 trapped read data zero", 32'h0);
    peek("R13 word kept", 32'h40);
    cfg_none();
    do_acc(2'd1, 1'b1, 32'h05); chk_res("R13 EL1 write done", R_DONE, 6'h0);
    do_acc(2'd1, 1'b0, '0); chk_res("R13 EL1 read done", R_DONE, 6'h0);
    chk_rd("R13 EL1 write stored", 32'h05);
  endtask

  initial begin
    cfg_none();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_layout();
    t_decode();
    t_el0_write();
    t_el3_always();
    t_el1_chain();
    t_el0_fgt();
    t_paths();
    t_el2();
    t_gating();
    t_commit();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule